// File: doc/BRIEF.md
# Split-Mode Performance Counter Bank

This block holds four 32-bit physical event counters behind a 64-bit memory-mapped register port. Each physical counter can be configured either as one 32-bit counter or as two independent 16-bit counters, so there are eight logical counters. Each logical counter has its own event input. While the monitor is enabled, a counter advances by one in every cycle that its event input is high.

Software never writes a running counter directly. A write to a counter register loads a staging latch and marks that latch pending. Pending latches move into the live counters only when software writes the control register with the enable bit set, and this includes a rewrite while the monitor is already enabled. When a counter or a 16-bit half wraps, it sets a sticky status bit. Reading the status register returns these bits and clears them in the same access. A mask register selects which status bits drive the interrupt output.

Top module: `perf_counter_bank`

## Requirements
- R1: After reset, all counters, latches, pending flags, the control register, the status bits and the interrupt mask are zero, and `irq` is low.
- R2: The word address selects the register: 0 is control, 1 is status/mask, and 2..5 are physical counters 0..3. Register data travels in bits 63:32 of the bus word. Bits 31:0 are ignored on write and read as zero. Any other address reads as zero, and `busRdata` is zero when `busRd` is low.
- R3: A write to a counter register loads only that counter's latch. A counter read returns the live value, which the write leaves unchanged.
- R4: A control write with bit 0 (enable) set copies every pending latch into its live counter and clears the pending flags. Counters without a pending latch are left alone. The load takes priority over counting in that cycle. A control write with bit 0 clear commits nothing.
- R5: While control bit 0 is set, a 32-bit counter p increments by one in each cycle that `evtIn[p]` is high. While bit 0 is clear, all counters hold their value.
- R6: Control bit 8+p set puts counter p in split mode. In split mode, bits 31:16 count `evtIn[p]` and bits 15:0 count `evtIn[p+4]`. In 32-bit mode, `evtIn[p+4]` has no effect.
- R7: In split mode, each half wraps from 0xFFFF to 0 independently, with no carry into the other half. An upper-half wrap sets status bit p and a lower-half wrap sets status bit p+4.
- R8: A 32-bit counter p wrapping from 0xFFFFFFFF to 0 sets status bit p.
- R9: A read of address 1 returns the status bits in data bits 7:0 and clears them at that clock edge. A wrap that occurs in the same cycle as the read remains set.
- R10: A write to address 1 loads the 8-bit interrupt mask. `irq` is the OR of status AND mask, so a zero mask keeps `irq` low, and `irq` falls in the cycle after a status read that clears the bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| busAddr | input | 3 | Register word address |
| busWr | input | 1 | Write strobe |
| busRd | input | 1 | Read strobe (status read clears) |
| busWdata | input | 64 | Write data, register in bits 63:32 |
| busRdata | output | 64 | Read data, register in bits 63:32 |
| evtIn | input | 8 | Event inputs, one per logical counter |
| irq | output | 1 | Masked counter-wrap interrupt |

## Verification
The hardest case to reach is a wrap that lands in the same cycle as a status read. The bench does this by committing 0xFFFFFFFF into a counter, then raising that counter's event in the very cycle that it issues the status read. The read must return the old status, and a second read must show the new wrap bit. A second hard case is a lower-half wrap that must not carry into the upper half. The bench commits 0x0000FFFE in split mode and pulses only the lower event across the wrap point. Latch staging is checked by reading each counter between the latch write and the commit.

// File: rtl/perfbank_pkg.sv
package perfbank_pkg;
  localparam int NUM_PHYS   = 4;
  localparam int CNT_W      = 32;
  localparam int HALF_W     = CNT_W / 2;
  localparam int NUM_LOG    = 2 * NUM_PHYS;
  localparam int BUS_W      = 64;
  localparam int ADDR_W     = 3;
  localparam int ADDR_CTRL  = 0;
  localparam int ADDR_STAT  = 1;
  localparam int ADDR_CNT0  = 2;
  localparam int EN_BIT     = 0;
  localparam int SPLIT_LSB  = 8;

  typedef struct packed {
    logic [NUM_PHYS-1:0] latchWr;
    logic                commit;
    logic                countEn;
    logic [NUM_PHYS-1:0] splitMode;
  } dpStrobe_t;
endpackage

// File: rtl/perfbank_ctrl.sv
module perfbank_ctrl
  import perfbank_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [CNT_W-1:0]  wordIn,
  input  logic [NUM_LOG-1:0] wrapHit,
  output dpStrobe_t         strobe,
  output logic [CNT_W-1:0]  ctrlWord,
  output logic [NUM_LOG-1:0] statusWord,
  output logic              irq
);
  logic [CNT_W-1:0]   ctrlReg;
  logic [NUM_LOG-1:0] maskReg;
  logic [NUM_LOG-1:0] statusReg;
  logic wrCtrl, wrStat, rdStat;

  assign wrCtrl = busWr && (busAddr == ADDR_W'(ADDR_CTRL));
  assign wrStat = busWr && (busAddr == ADDR_W'(ADDR_STAT));
  assign rdStat = busRd && (busAddr == ADDR_W'(ADDR_STAT));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg   <= '0;
      maskReg   <= '0;
      statusReg <= '0;
    end else begin
      if (wrCtrl) ctrlReg <= wordIn;
      if (wrStat) maskReg <= wordIn[NUM_LOG-1:0];
      statusReg <= (rdStat ? '0 : statusReg) | wrapHit;
    end
  end

  always_comb begin
    for (int p = 0; p < NUM_PHYS; p++)
      strobe.latchWr[p] = busWr && (busAddr == ADDR_W'(ADDR_CNT0 + p));
    strobe.commit    = wrCtrl && wordIn[EN_BIT];
    strobe.countEn   = ctrlReg[EN_BIT];
    strobe.splitMode = ctrlReg[SPLIT_LSB +: NUM_PHYS];
  end

  assign ctrlWord   = ctrlReg;
  assign statusWord = statusReg;
  assign irq        = |(statusReg & maskReg);

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    rdStat && (wrapHit == '0) |=> statusReg == '0); // R9
  AST_IRQ_FALLS: assert property (@(posedge clk) disable iff (!rstN)
    rdStat && (wrapHit == '0) |=> !irq); // R10
  AST_WRAP_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (wrapHit != '0) |=> ((statusReg & $past(wrapHit)) == $past(wrapHit))); // R7
endmodule

// File: rtl/perfbank_datapath.sv
module perfbank_datapath
  import perfbank_pkg::*;
(
  input  logic                           clk,
  input  logic                           rstN,
  input  dpStrobe_t                      strobe,
  input  logic [CNT_W-1:0]               wordIn,
  input  logic [NUM_LOG-1:0]             evtIn,
  output logic [NUM_PHYS-1:0][CNT_W-1:0] cntOut,
  output logic [NUM_LOG-1:0]             wrapHit
);
  for (genvar p = 0; p < NUM_PHYS; p++) begin : g_phys
    logic [CNT_W-1:0]  cntQ, latchQ, cntNext;
    logic              pendQ, load, incFull, incHi, incLo;
    logic [HALF_W-1:0] upper, lower;

    assign upper   = cntQ[CNT_W-1:HALF_W];
    assign lower   = cntQ[HALF_W-1:0];
    assign load    = strobe.commit && pendQ;
    assign incFull = strobe.countEn && !strobe.splitMode[p] && evtIn[p];
    assign incHi   = strobe.countEn &&  strobe.splitMode[p] && evtIn[p];
    assign incLo   = strobe.countEn &&  strobe.splitMode[p] && evtIn[p+NUM_PHYS];

    always_comb begin
      if (load)
        cntNext = latchQ;
      else if (strobe.splitMode[p])
        cntNext = {upper + HALF_W'(incHi), lower + HALF_W'(incLo)};
      else
        cntNext = cntQ + CNT_W'(incFull);
    end

    assign wrapHit[p] = !load && ((incFull && (cntQ == '1)) || (incHi && (upper == '1)));
    assign wrapHit[p+NUM_PHYS] = !load && incLo && (lower == '1);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        cntQ   <= '0;
        latchQ <= '0;
        pendQ  <= 1'b0;
      end else begin
        cntQ <= cntNext;
        if (strobe.latchWr[p]) begin
          latchQ <= wordIn;
          pendQ  <= 1'b1;
        end else if (strobe.commit) begin
          pendQ  <= 1'b0;
        end
      end
    end

    assign cntOut[p] = cntQ;

    AST_COMMIT_LOADS: assert property (@(posedge clk) disable iff (!rstN)
      strobe.commit && pendQ |=> cntQ == $past(latchQ)); // R4
    AST_LATCH_ONLY: assert property (@(posedge clk) disable iff (!rstN)
      strobe.latchWr[p] && !strobe.countEn |=> $stable(cntQ)); // R3
    AST_NO_CARRY: assert property (@(posedge clk) disable iff (!rstN)
      strobe.countEn && !strobe.commit && strobe.splitMode[p] && (lower == '1)
      && evtIn[p+NUM_PHYS] && !evtIn[p] |=> $stable(upper)); // R7
  end

  AST_HOLD_DISABLED: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.countEn && !strobe.commit |=> $stable(cntOut)); // R5
endmodule

// File: rtl/perf_counter_bank.sv
module perf_counter_bank
  import perfbank_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [BUS_W-1:0]  busWdata,
  output logic [BUS_W-1:0]  busRdata,
  input  logic [NUM_LOG-1:0] evtIn,
  output logic              irq
);
  dpStrobe_t                      strobe;
  logic [CNT_W-1:0]               ctrlWord, wordIn, rdWord;
  logic [NUM_LOG-1:0]             statusWord, wrapHit;
  logic [NUM_PHYS-1:0][CNT_W-1:0] cntOut;

  assign wordIn = busWdata[BUS_W-1 -: CNT_W];

  perfbank_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .wordIn(wordIn), .wrapHit(wrapHit), .strobe(strobe), .ctrlWord(ctrlWord),
    .statusWord(statusWord), .irq(irq)
  );

  perfbank_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wordIn(wordIn), .evtIn(evtIn),
    .cntOut(cntOut), .wrapHit(wrapHit)
  );

  always_comb begin
    rdWord = '0;
    if (busAddr == ADDR_W'(ADDR_CTRL))
      rdWord = ctrlWord;
    else if (busAddr == ADDR_W'(ADDR_STAT))
      rdWord = CNT_W'(statusWord);
    else
      for (int p = 0; p < NUM_PHYS; p++)
        if (busAddr == ADDR_W'(ADDR_CNT0 + p)) rdWord = cntOut[p];
  end

  assign busRdata = busRd ? {rdWord, {(BUS_W-CNT_W){1'b0}}} : '0;
endmodule

// File: tb/perf_counter_bank_tb.sv
module perf_counter_bank_tb;
  logic        clk = 0;
  logic        rstN = 0;
  logic [2:0]  busAddr = 0;
  logic        busWr = 0, busRd = 0;
  logic [63:0] busWdata = 0;
  logic [63:0] busRdata;
  logic [7:0]  evtIn = 0;
  logic        irq;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  perf_counter_bank u_dut (.clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr),
    .busRd(busRd), .busWdata(busWdata), .busRdata(busRdata), .evtIn(evtIn), .irq(irq));

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); busAddr = a; busWdata = {d, 32'hDEAD_BEEF}; busWr = 1;
    @(posedge clk); #1 busWr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [63:0] d);
    @(negedge clk); busAddr = a; busRd = 1; #1 d = busRdata;
    @(posedge clk); #1 busRd = 0;
  endtask

  task automatic pulse(input int idx, input int n);
    @(negedge clk); evtIn[idx] = 1;
    repeat (n) @(negedge clk);
    evtIn[idx] = 0;
  endtask

  task automatic t_reset();
    logic [63:0] d;
    check("R1 irq", {63'b0, irq}, 0);
    rd(0, d); check("R1 ctrl", d, 0);
    rd(1, d); check("R1 status", d, 0);
    for (int i = 2; i < 6; i++) begin rd(i[2:0], d); check("R1 counter", d, 0); end
    rd(7, d); check("R2 unmapped", d, 0);
    check("R2 idle rdata", busRdata, 0);
  endtask

  task automatic t_latch();
    logic [63:0] d;
    wr(3, 32'h1234_5678);
    rd(3, d); check("R3 live unchanged", d, 0);
    wr(0, 32'h1);
    rd(3, d); check("R4 commit", d, 64'h1234_5678_0000_0000);
    rd(2, d); check("R4 non-pending kept", d, 0);
    wr(4, 32'h55);
    rd(4, d); check("R3 write while enabled", d, 0);
    wr(0, 32'h1);
    rd(4, d); check("R4 rewrite commit", d, 64'h55_0000_0000);
    wr(0, 32'h0);
    wr(5, 32'h9);
    wr(0, 32'h0);
    rd(5, d); check("R4 no commit when disabled", d, 0);
  endtask

  task automatic t_count();
    logic [63:0] d;
    wr(0, 32'h1);
    pulse(0, 5);
    rd(2, d); check("R5 count", d, 64'h5_0000_0000);
    wr(0, 32'h0);
    pulse(0, 3);
    rd(2, d); check("R5 hold disabled", d, 64'h5_0000_0000);
    wr(0, 32'h1);
    pulse(4, 3);
    rd(2, d); check("R6 lower event ignored in 32-bit", d, 64'h5_0000_0000);
  endtask

  task automatic t_split();
    logic [63:0] d;
    wr(3, 32'h0000_FFFE);
    wr(0, 32'h201);
    pulse(5, 3);
    rd(3, d); check("R7 lower wrap no carry", d, 64'h0000_0001_0000_0000);
    pulse(1, 2);
    rd(3, d); check("R6 upper counts", d, 64'h0002_0001_0000_0000);
    rd(1, d); check("R7 lower status bit", d, 64'h20_0000_0000);
    rd(1, d); check("R9 cleared", d, 0);
    wr(3, 32'hFFFF_0005);
    wr(0, 32'h201);
    pulse(1, 1);
    rd(3, d); check("R7 upper wrap", d, 64'h0000_0005_0000_0000);
    rd(1, d); check("R7 upper status bit", d, 64'h02_0000_0000);
  endtask

  task automatic t_wrap32_irq();
    logic [63:0] d;
    wr(4, 32'hFFFF_FFFF);
    wr(0, 32'h1);
    pulse(2, 1);
    rd(4, d); check("R8 32-bit wrap", d, 0);
    check("R10 zero mask", {63'b0, irq}, 0);
    wr(1, 32'h04);
    check("R10 irq raised", {63'b0, irq}, 1);
    rd(1, d); check("R8 status bit", d, 64'h04_0000_0000);
    check("R10 irq falls", {63'b0, irq}, 0);
  endtask

  task automatic t_read_race();
    logic [63:0] d;
    wr(5, 32'hFFFF_FFFF);
    wr(0, 32'h1);
    @(negedge clk); evtIn[3] = 1; busAddr = 1; busRd = 1; #1 d = busRdata;
    check("R9 read before wrap", d, 0);
    @(posedge clk); #1 busRd = 0;
    @(negedge clk); evtIn[3] = 0;
    rd(1, d); check("R9 same-cycle wrap kept", d, 64'h08_0000_0000);
    rd(5, d); check("R8 wrapped to zero", d, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    t_reset();
    t_latch();
    t_count();
    t_split();
    t_wrap32_irq();
    t_read_race();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule